// File: doc/BRIEF.md
# Multi-Space External Bus Sequencer

This block is the front end of an external memory bus. In one machine cycle a processor core can present up to three requests: a data write, a data read and a program fetch. The sequencer latches whatever is pending in that cycle and plays the requests out one after another over a single shared 16-bit address bus and a single 16-bit data bus. It always runs the write first, then the read, then the fetch. Each access drives one active-low space-select strobe: program, data or I/O.

Every access lasts one base cycle plus a programmable number of wait states. The count comes from a 12-bit wait configuration word, which splits program space into a lower and an upper half and gives data space and I/O space one field each. A second configuration word, the global map, marks part of the upper half of data space as global. Any data-space access that lands there pulls an active-low bus-request line low for the whole access, in step with the address.

The sequencer has four states. `ST_IDLE` waits for requests. `ST_WRITE`, `ST_READ` and `ST_FETCH` each hold one external access.
- From `ST_IDLE` it goes to the first pending state in the fixed order.
- On the final cycle of an access it moves to the next state in the order that still has a request pending, or back to `ST_IDLE` if none does.
- It stays in an access state until the wait counter reaches zero.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset the sequencer is idle and all three strobes and the bus-request line are high. The wait word is 0x0FFF, so every access takes 8 cycles until the word is reloaded.
- R2: Requests seen together while idle run as write, then read, then fetch. A request that was not asserted is skipped.
- R3: During an access exactly one strobe is low. A fetch drives `ps_n` low. A write or read drives `is_n` low when its I/O flag is set and `ds_n` low otherwise. No strobe is low while idle.
- R4: An access takes 1 + W cycles, where W is a field of the wait word: bits [2:0] for a fetch below 0x8000, bits [5:3] for a fetch at or above 0x8000, bits [8:6] for a data-space write or read, and bits [11:9] for an I/O write or read.
- R5: The address of an access is stable for all of its cycles. `ext_we` is high only during a write, and a write drives its data on `ext_wdata`.
- R6: The cycle after the final cycle of an access, the matching done output pulses for one cycle. After a read or a fetch, `rd_data` or `pf_data` then holds the value `ext_rdata` had on that final cycle.
- R7: Let K be the number of consecutive ones in the global map counted from bit 7 downward; bits after the first zero have no effect. A data-space access to an address A with A[15]=1 and 7 − A[14:12] < K drives `br_n` low. Every other access, including all I/O and program accesses, leaves `br_n` high.
- R8: Requests presented while the sequencer is not idle are ignored and start no access.
- R9: The next queued access starts in the cycle right after the final cycle of the previous one. After the last queued access the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wsr_we | input | 1 | Load the wait configuration word |
| wsr_wdata | input | 12 | New wait configuration word |
| gmap_we | input | 1 | Load the global map |
| gmap_wdata | input | 8 | New global map |
| wr_req | input | 1 | Data write request |
| wr_io | input | 1 | Write targets I/O space |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| rd_req | input | 1 | Data read request |
| rd_io | input | 1 | Read targets I/O space |
| rd_addr | input | 16 | Read address |
| pf_req | input | 1 | Program fetch request |
| pf_addr | input | 16 | Fetch address |
| ext_rdata | input | 16 | External read data bus |
| seq_idle | output | 1 | Sequencer idle; requests are sampled |
| ext_addr | output | 16 | External address bus |
| ext_wdata | output | 16 | External write data bus |
| ext_we | output | 1 | Write enable, high during a write |
| ps_n | output | 1 | Program space select, active low |
| ds_n | output | 1 | Data space select, active low |
| is_n | output | 1 | I/O space select, active low |
| br_n | output | 1 | Global access bus request, active low |
| wr_done | output | 1 | Write finished pulse |
| rd_done | output | 1 | Read finished pulse |
| rd_data | output | 16 | Captured read data |
| pf_done | output | 1 | Fetch finished pulse |
| pf_data | output | 16 | Captured fetch data |

## Verification
Two events share a cycle whenever requests are queued back to back: the end of one access, with its done pulse and data capture, and the first cycle of the next access, with its new address and strobe. The bench provokes this by sweeping every non-empty mix of the three requests against varied wait fields and space flags. In each cycle it checks the address, the strobes, the bus request and the done vector against a schedule it builds arithmetically from the wait word, so a one-cycle slip on either side shows up. It also injects extra requests on the first cycle of a busy sequence and confirms that the bus goes idle right after the expected accesses.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_FETCH = 2'd3
    } bus_state_e;
endpackage

// File: rtl/ebs_wait_sel.sv
// Picks the wait-state field for one access from the packed wait word.
module ebs_wait_sel #(
    parameter int WSW = 3
) (
    input  logic [4*WSW-1:0] wsr,
    input  logic             is_prog,
    input  logic             is_io,
    input  logic             addr_hi,
    output logic [WSW-1:0]   ws
);
    localparam int NFLD = 4;

    logic [WSW-1:0] fld [NFLD];

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        assign fld[g] = wsr[g*WSW +: WSW];
    end

    always_comb begin
        if (is_prog)    ws = addr_hi ? fld[1] : fld[0];
        else if (is_io) ws = fld[3];
        else            ws = fld[2];
    end
endmodule

// File: rtl/ebs_glob_dec.sv
// Global / local decode for the upper half of data space.
module ebs_glob_dec #(
    parameter int AW   = 16,
    parameter int NBLK = 8
) (
    input  logic [NBLK-1:0] gmap,
    input  logic [AW-1:0]   addr,
    input  logic            data_sp,
    output logic            glob
);
    localparam int BLKB = $clog2(NBLK);
    localparam int CNTW = $clog2(NBLK + 1);

    logic [CNTW-1:0] lead;
    logic [BLKB-1:0] blk;
    logic [CNTW-1:0] from_top;

    always_comb begin
        logic run;
        run  = 1'b1;
        lead = '0;
        for (int i = NBLK - 1; i >= 0; i--) begin
            if (run && gmap[i]) lead = lead + 1'b1;
            else                run  = 1'b0;
        end
    end

    assign blk      = addr[AW-2 -: BLKB];
    assign from_top = CNTW'(NBLK - 1) - CNTW'(blk);
    assign glob     = data_sp && addr[AW-1] && (from_top < lead);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int WSW  = 3,
    parameter int NBLK = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wsr_we,
    input  logic [4*WSW-1:0]  wsr_wdata,
    input  logic              gmap_we,
    input  logic [NBLK-1:0]   gmap_wdata,
    input  logic              wr_req,
    input  logic              wr_io,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_req,
    input  logic              rd_io,
    input  logic [AW-1:0]     rd_addr,
    input  logic              pf_req,
    input  logic [AW-1:0]     pf_addr,
    input  logic [DW-1:0]     ext_rdata,
    output logic              seq_idle,
    output logic [AW-1:0]     ext_addr,
    output logic [DW-1:0]     ext_wdata,
    output logic              ext_we,
    output logic              ps_n,
    output logic              ds_n,
    output logic              is_n,
    output logic              br_n,
    output logic              wr_done,
    output logic              rd_done,
    output logic [DW-1:0]     rd_data,
    output logic              pf_done,
    output logic [DW-1:0]     pf_data
);
    localparam int WSRW = 4 * WSW;

    bus_state_e state_q, state_d;
    logic [WSW-1:0]  cnt_q, ws_nxt;
    logic [WSRW-1:0] wsr_q;
    logic [NBLK-1:0] gmap_q;
    logic            wr_p, rd_p, pf_p, wr_io_q, rd_io_q;
    logic [AW-1:0]   wr_addr_q, rd_addr_q, pf_addr_q, nx_addr;
    logic [DW-1:0]   wr_data_q;
    logic            nx_io, last_cyc, in_idle, data_sp, glob;

    assign in_idle  = (state_q == ST_IDLE);
    assign last_cyc = !in_idle && (cnt_q == '0);

    // Configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsr_q  <= '1;
            gmap_q <= '0;
        end else begin
            if (wsr_we)  wsr_q  <= wsr_wdata;
            if (gmap_we) gmap_q <= gmap_wdata;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req)      state_d = ST_WRITE;
                else if (rd_req) state_d = ST_READ;
                else if (pf_req) state_d = ST_FETCH;
            end
            ST_WRITE: if (last_cyc) state_d = rd_p ? ST_READ : (pf_p ? ST_FETCH : ST_IDLE);
            ST_READ:  if (last_cyc) state_d = pf_p ? ST_FETCH : ST_IDLE;
            ST_FETCH: if (last_cyc) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Address and space of the access about to start
    always_comb begin
        nx_addr = '0;
        nx_io   = 1'b0;
        unique case (state_d)
            ST_WRITE: begin
                nx_addr = in_idle ? wr_addr : wr_addr_q;
                nx_io   = in_idle ? wr_io   : wr_io_q;
            end
            ST_READ: begin
                nx_addr = in_idle ? rd_addr : rd_addr_q;
                nx_io   = in_idle ? rd_io   : rd_io_q;
            end
            ST_FETCH: nx_addr = in_idle ? pf_addr : pf_addr_q;
            default: ;
        endcase
    end

    ebs_wait_sel #(.WSW(WSW)) i_wait_sel (
        .wsr     (wsr_q),
        .is_prog (state_d == ST_FETCH),
        .is_io   (nx_io),
        .addr_hi (nx_addr[AW-1]),
        .ws      (ws_nxt)
    );

    // State register, wait counter, request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            wr_p      <= 1'b0;
            rd_p      <= 1'b0;
            pf_p      <= 1'b0;
            wr_io_q   <= 1'b0;
            rd_io_q   <= 1'b0;
            wr_addr_q <= '0;
            rd_addr_q <= '0;
            pf_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != ST_IDLE && (in_idle || last_cyc)) cnt_q <= ws_nxt;
            else if (cnt_q != '0)                             cnt_q <= cnt_q - 1'b1;
            if (in_idle) begin
                wr_p      <= wr_req;
                rd_p      <= rd_req;
                pf_p      <= pf_req;
                wr_io_q   <= wr_io;
                rd_io_q   <= rd_io;
                wr_addr_q <= wr_addr;
                rd_addr_q <= rd_addr;
                pf_addr_q <= pf_addr;
                wr_data_q <= wr_data;
            end else if (last_cyc) begin
                if (state_q == ST_WRITE) wr_p <= 1'b0;
                if (state_q == ST_READ)  rd_p <= 1'b0;
                if (state_q == ST_FETCH) pf_p <= 1'b0;
            end
        end
    end

    // Completion pulses and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_done <= 1'b0;
            rd_done <= 1'b0;
            pf_done <= 1'b0;
            rd_data <= '0;
            pf_data <= '0;
        end else begin
            wr_done <= last_cyc && (state_q == ST_WRITE);
            rd_done <= last_cyc && (state_q == ST_READ);
            pf_done <= last_cyc && (state_q == ST_FETCH);
            if (last_cyc && state_q == ST_READ)  rd_data <= ext_rdata;
            if (last_cyc && state_q == ST_FETCH) pf_data <= ext_rdata;
        end
    end

    assign data_sp = (state_q == ST_WRITE && !wr_io_q) || (state_q == ST_READ && !rd_io_q);

    ebs_glob_dec #(.AW(AW), .NBLK(NBLK)) i_glob_dec (
        .gmap    (gmap_q),
        .addr    (ext_addr),
        .data_sp (data_sp),
        .glob    (glob)
    );

    // Bus outputs from the current state
    always_comb begin
        seq_idle  = in_idle;
        ext_addr  = '0;
        ext_wdata = wr_data_q;
        ext_we    = 1'b0;
        ps_n      = 1'b1;
        ds_n      = 1'b1;
        is_n      = 1'b1;
        unique case (state_q)
            ST_WRITE: begin
                ext_addr = wr_addr_q;
                ext_we   = 1'b1;
                ds_n     = wr_io_q;
                is_n     = !wr_io_q;
            end
            ST_READ: begin
                ext_addr = rd_addr_q;
                ds_n     = rd_io_q;
                is_n     = !rd_io_q;
            end
            ST_FETCH: begin
                ext_addr = pf_addr_q;
                ps_n     = 1'b0;
            end
            default: ;
        endcase
        br_n = !glob;
    end

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ps_n, ds_n, is_n}) == (seq_idle ? 3 : 2));

    // R2
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> !wr_p);

    // R2
    fetch_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |-> (!wr_p && !rd_p));

    // R4
    wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_idle && cnt_q != '0) |=> (state_q == $past(state_q) && cnt_q == $past(cnt_q) - 1'b1));

    // R5
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_idle && cnt_q != '0) |=> $stable(ext_addr));

    // R6
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_done, rd_done, pf_done}));

    // R6
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cyc && state_q == ST_READ) |=> (rd_done && rd_data == $past(ext_rdata)));

    // R7
    br_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_n || !is_n || seq_idle) |-> br_n);

    // R9
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cyc && state_q == ST_WRITE && rd_p) |=> (state_q == ST_READ));
endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wsr_we = 0, gmap_we = 0;
    logic [11:0] wsr_wdata = '0;
    logic [7:0]  gmap_wdata = '0;
    logic        wr_req = 0, wr_io = 0, rd_req = 0, rd_io = 0, pf_req = 0;
    logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0, pf_addr = '0;
    logic [15:0] ext_rdata;
    logic        seq_idle, ext_we, ps_n, ds_n, is_n, br_n;
    logic        wr_done, rd_done, pf_done;
    logic [15:0] ext_addr, ext_wdata, rd_data, pf_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [11:0] cur_wsr = 12'hFFF;
    logic [7:0]  cur_gmap = 8'h00;

    always #5 clk = ~clk;

    assign ext_rdata = ext_addr ^ 16'h5A3C;

    ext_bus_seq i_ext_bus_seq (
        .clk(clk), .rst_n(rst_n),
        .wsr_we(wsr_we), .wsr_wdata(wsr_wdata),
        .gmap_we(gmap_we), .gmap_wdata(gmap_wdata),
        .wr_req(wr_req), .wr_io(wr_io), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_io(rd_io), .rd_addr(rd_addr),
        .pf_req(pf_req), .pf_addr(pf_addr),
        .ext_rdata(ext_rdata), .seq_idle(seq_idle),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we),
        .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n), .br_n(br_n),
        .wr_done(wr_done), .rd_done(rd_done), .rd_data(rd_data),
        .pf_done(pf_done), .pf_data(pf_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_ws(input int kind, input bit io, input logic [15:0] a);
        if (kind == 2) return a[15] ? int'(cur_wsr[5:3]) : int'(cur_wsr[2:0]);
        if (io)        return int'(cur_wsr[11:9]);
        return int'(cur_wsr[8:6]);
    endfunction

    function automatic bit exp_glob(input int kind, input bit io, input logic [15:0] a);
        int k = 0;
        bit run = 1;
        if (kind == 2 || io || !a[15]) return 0;
        for (int i = 7; i >= 0; i--) begin
            if (run && cur_gmap[i]) k++;
            else run = 0;
        end
        return (7 - int'(a[14:12])) < k;
    endfunction

    task automatic set_cfg(input logic [11:0] w, input logic [7:0] g);
        wsr_we = 1; wsr_wdata = w; gmap_we = 1; gmap_wdata = g;
        @(negedge clk);
        wsr_we = 0; gmap_we = 0;
        cur_wsr = w; cur_gmap = g;
    endtask

    // Runs one batch; entered and left at a negedge with the sequencer idle.
    task automatic run_batch(input bit w, input bit r, input bit f,
                             input bit wio, input bit rio,
                             input logic [15:0] wa, input logic [15:0] wd,
                             input logic [15:0] ra, input logic [15:0] fa,
                             input bit junk);
        bit          pend [3];
        bit          io;
        logic [15:0] a;
        logic [2:0]  prev_done = 3'b000;
        int          prev_kind = -1;
        logic [15:0] prev_a = '0;
        bit          first = 1;
        pend[0] = w; pend[1] = r; pend[2] = f;
        chk(seq_idle === 1'b1, "R9 idle before batch", 32'(seq_idle), 1);
        wr_req = w; rd_req = r; pf_req = f; wr_io = wio; rd_io = rio;
        wr_addr = wa; wr_data = wd; rd_addr = ra; pf_addr = fa;
        @(negedge clk);
        wr_req = 0; rd_req = 0; pf_req = 0;
        for (int kind = 0; kind < 3; kind++) begin
            if (!pend[kind]) continue;
            a  = (kind == 0) ? wa : (kind == 1) ? ra : fa;
            io = (kind == 0) ? wio : (kind == 1) ? rio : 1'b0;
            for (int c = 0; c <= exp_ws(kind, io, a); c++) begin
                logic [2:0] es;
                logic [2:0] ed;
                es = (kind == 2) ? 3'b011 : (io ? 3'b110 : 3'b101);
                ed = (c == 0) ? prev_done : 3'b000;
                chk(seq_idle === 1'b0, "R9 busy", 32'(seq_idle), 0);
                chk(ext_addr === a, "R5 address", 32'(ext_addr), 32'(a));
                chk({ps_n, ds_n, is_n} === es, "R3 strobes", 32'({ps_n, ds_n, is_n}), 32'(es));
                chk(ext_we === (kind == 0), "R5 write enable", 32'(ext_we), 32'(kind == 0));
                if (kind == 0) chk(ext_wdata === wd, "R5 write data", 32'(ext_wdata), 32'(wd));
                chk(br_n === !exp_glob(kind, io, a), "R7 bus request", 32'(br_n), 32'(!exp_glob(kind, io, a)));
                chk({wr_done, rd_done, pf_done} === ed, "R6 R4 done timing",
                    32'({wr_done, rd_done, pf_done}), 32'(ed));
                if (c == 0 && prev_kind == 1) chk(rd_data === (prev_a ^ 16'h5A3C), "R6 read data", 32'(rd_data), 32'(prev_a ^ 16'h5A3C));
                if (c == 0 && prev_kind == 2) chk(pf_data === (prev_a ^ 16'h5A3C), "R6 fetch data", 32'(pf_data), 32'(prev_a ^ 16'h5A3C));
                if (first && junk) begin
                    wr_req = 1; rd_req = 1; pf_req = 1; wr_io = 1; rd_io = 1;
                    wr_addr = 16'hDEAD; rd_addr = 16'hBEEF; pf_addr = 16'hCAFE;
                end
                first = 0;
                @(negedge clk);
                wr_req = 0; rd_req = 0; pf_req = 0;
            end
            prev_done = 3'b100 >> kind;
            prev_kind = kind;
            prev_a = a;
        end
        chk(seq_idle === 1'b1, "R9 R8 idle after batch", 32'(seq_idle), 1);
        chk({ps_n, ds_n, is_n, br_n} === 4'b1111, "R3 R8 no strobe after batch", 32'({ps_n, ds_n, is_n, br_n}), 32'hF);
        chk({wr_done, rd_done, pf_done} === prev_done, "R6 last done", 32'({wr_done, rd_done, pf_done}), 32'(prev_done));
        if (prev_kind == 1) chk(rd_data === (prev_a ^ 16'h5A3C), "R6 read data", 32'(rd_data), 32'(prev_a ^ 16'h5A3C));
        if (prev_kind == 2) chk(pf_data === (prev_a ^ 16'h5A3C), "R6 fetch data", 32'(pf_data), 32'(prev_a ^ 16'h5A3C));
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(seq_idle === 1'b1, "R1 idle after reset", 32'(seq_idle), 1);
        chk({ps_n, ds_n, is_n, br_n} === 4'b1111, "R1 strobes high", 32'({ps_n, ds_n, is_n, br_n}), 32'hF);
        chk({wr_done, rd_done, pf_done} === 3'b000, "R1 no done", 32'({wr_done, rd_done, pf_done}), 0);
        // R1 default wait word: every access is 8 cycles
        run_batch(1, 1, 1, 0, 1, 16'h1234, 16'hA55A, 16'h0042, 16'h9000, 0);

        // R2 R4 R7 sweep over request mixes, spaces, wait fields and global maps
        for (int g = 0; g <= 8; g++) begin
            logic [7:0] gm;
            gm = ~(8'hFF >> g);
            if (g <= 6) gm[0] = 1'b1;
            for (int mix = 1; mix < 8; mix++) begin
                for (int sp = 0; sp < 4; sp++) begin
                    logic [11:0] wv;
                    logic [15:0] wa, ra, fa;
                    wv = {3'((g + sp) % 4), 3'((mix + sp) % 4), 3'((g + mix) % 4), 3'(sp % 3)};
                    set_cfg(wv, gm);
                    wa = 16'h8000 + 16'((mix * 16'h1357 + g * 16'h0FFF) & 16'hFFFF);
                    ra = 16'((g * 16'h2000 + mix * 16'h0911 + sp * 16'h4321) & 16'hFFFF);
                    fa = 16'((sp * 16'h4000 + mix * 16'h0123) & 16'hFFFF);
                    run_batch(mix[2], mix[1], mix[0], sp[0], sp[1], wa, 16'(mix * 16'h0F0F + g), ra, fa, (mix == 7 && sp == 0));
                end
            end
        end

        // R7 R8 exhaustive block sweep with zero waits
        for (int g = 0; g <= 8; g++) begin
            set_cfg(12'h000, ~(8'hFF >> g));
            for (int b = 0; b < 16; b++) begin
                logic [15:0] a;
                a = 16'(b << 12) | 16'h0ABC;
                run_batch(0, 1, 0, 0, 0, 16'h0, 16'h0, a, 16'h0, 0);
                run_batch(1, 0, 1, 1, 0, a, 16'h1111, 16'h0, a, 1);
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule